// File: doc/BRIEF.md
# Saturating Executed-Instruction Counter

This block counts the instructions retired during the current or most recent operation of a programmable engine. An operation-start pulse carries a two-bit operation kind. The counter clears on every start, and it advances only while the operation in progress is a program run. Retire pulses that carry an error flag are not counted. The count stops at its all-ones value instead of wrapping around.

The value that software reads is forced to zero while the engine is locked. The stored count is kept underneath the mask. Decoding and executing instructions are handled outside the block. The block only sees a retire strobe, with an error qualifier, for each instruction that completes.

Top module: `insn_exec_counter`

## Requirements
- R1: The count saturates at 2^CNT_W-1 (CNT_W defaults to 32). A further good retire leaves it at that value and never wraps it to zero.
- R2: A cycle with `op_start_i` high makes the count 0 on the next cycle, whatever its previous value was.
- R3: Only operation kind 2'd0 (program run) allows counting. After a start with kind 2'd1 (data wipe), 2'd2 (instruction wipe) or 2'd3 (unused code), retire pulses leave the count at 0.
- R4: A retire pulse with `retire_err_i` high leaves the count unchanged.
- R5: While `locked_i` is high, `count_o` reads 0 in the same cycle. When `locked_i` falls, `count_o` shows the stored count again, unchanged by the masking.
- R6: During a program run, a retire pulse with `retire_err_i` low raises the count by exactly one on the next cycle, unless the count is already saturated.
- R7: After reset, `count_o` is 0. Retire pulses before the first start are not counted.
- R8: A start pulse and a retire pulse in the same cycle give a count of 0.
- R9: When no retire pulse and no start pulse arrive, the count holds its value, including after an operation has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_start_i | input | 1 | Operation start pulse |
| op_kind_i | input | 2 | Operation kind sampled with the start pulse (0 run, 1 data wipe, 2 instruction wipe, 3 unused) |
| retire_i | input | 1 | One instruction retired this cycle |
| retire_err_i | input | 1 | The retiring instruction raised an error |
| locked_i | input | 1 | Engine is locked; mask the read value |
| count_o | output | CNT_W | Instruction count as read by software |

## Verification
The bench runs the counter at a narrow width so that it can reach the ceiling. A design that wraps shows 0 after 2^CNT_W good retires instead of holding the all-ones value. It also checks a start arriving in the same cycle as a retire. A design that gives the increment priority reads 1 there instead of 0. The bench runs wipes and the unused kind with retires still arriving, where a counter that ignores the latched kind would climb. It toggles lock in the middle of a count, which exposes a mask that clears the stored value or a mask that leaks it.

// File: rtl/insn_cnt_pkg.sv
package insn_cnt_pkg;
   localparam int unsigned OP_KIND_W = 2;

   typedef enum logic [OP_KIND_W-1:0] {
      OP_RUN       = 2'd0,
      OP_WIPE_DATA = 2'd1,
      OP_WIPE_INSN = 2'd2,
      OP_UNUSED    = 2'd3
   } op_kind_e;

   function automatic logic kind_counts(input logic [OP_KIND_W-1:0] kind);
      return kind == OP_RUN;
   endfunction
endpackage

// File: rtl/insn_cnt_qual.sv
module insn_cnt_qual
   import insn_cnt_pkg::*;
(
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 start_i,
   input  logic [OP_KIND_W-1:0] kind_i,
   input  logic                 retire_i,
   input  logic                 err_i,
   output logic                 clr_o,
   output logic                 inc_o
);
   logic run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
      end else if (start_i) begin
         run_q <= kind_counts(kind_i);
      end
   end

   // start wins over a retire in the same cycle
   assign clr_o = start_i;
   assign inc_o = !start_i && run_q && retire_i && !err_i;
endmodule

// File: rtl/insn_cnt_sat.sv
module insn_cnt_sat #(
   parameter int unsigned CNT_W     = 32,
   parameter bit          USE_CARRY = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] nxt_val;
   logic             at_top;

   generate
      if (USE_CARRY) begin : g_carry
         logic carry;
         assign {carry, nxt_val} = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
         assign at_top = carry;
      end else begin : g_reduce
         assign nxt_val = cnt_q + 1'b1;
         assign at_top  = &cnt_q;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && !at_top) begin
         cnt_q <= nxt_val;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/insn_cnt_mask.sv
module insn_cnt_mask #(
   parameter int unsigned W = 32
) (
   input  logic         hide_i,
   input  logic [W-1:0] val_i,
   output logic [W-1:0] val_o
);
   assign val_o = hide_i ? '0 : val_i;
endmodule

// File: rtl/insn_exec_counter.sv
module insn_exec_counter
   import insn_cnt_pkg::*;
#(
   parameter int unsigned CNT_W         = 32,
   parameter bit          SAT_VIA_CARRY = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 op_start_i,
   input  logic [OP_KIND_W-1:0] op_kind_i,
   input  logic                 retire_i,
   input  logic                 retire_err_i,
   input  logic                 locked_i,
   output logic [CNT_W-1:0]     count_o
);
   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
         $error("insn_exec_counter: CNT_W must lie in 2..64");
      end
   endgenerate

   logic             clr;
   logic             inc;
   logic [CNT_W-1:0] raw_cnt;

   insn_cnt_qual u_qual (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (op_start_i),
      .kind_i  (op_kind_i),
      .retire_i(retire_i),
      .err_i   (retire_err_i),
      .clr_o   (clr),
      .inc_o   (inc)
   );

   insn_cnt_sat #(
      .CNT_W    (CNT_W),
      .USE_CARRY(SAT_VIA_CARRY)
   ) u_sat (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr),
      .inc_i (inc),
      .cnt_o (raw_cnt)
   );

   insn_cnt_mask #(.W(CNT_W)) u_mask (
      .hide_i(locked_i),
      .val_i (raw_cnt),
      .val_o (count_o)
   );
endmodule

// File: rtl/insn_exec_counter_chk.sv
module insn_exec_counter_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             op_start_i,
   input logic             retire_i,
   input logic             retire_err_i,
   input logic             locked_i,
   input logic [CNT_W-1:0] count_o
);
   // R2
   start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_start_i |=> count_o == '0);

   // R5
   locked_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked_i |-> count_o == '0);

   // R1
   no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!op_start_i && !locked_i) |=> (locked_i || count_o >= $past(count_o)));

   // R4
   err_no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (retire_i && retire_err_i && !op_start_i && !locked_i)
      |=> (locked_i || count_o == $past(count_o)));

   // R9
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!retire_i && !op_start_i && !locked_i)
      |=> (locked_i || $stable(count_o)));

   // R6
   single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!op_start_i && !locked_i)
      |=> (locked_i || (count_o - $past(count_o)) <= 1));
endmodule

bind insn_exec_counter insn_exec_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .op_start_i  (op_start_i),
   .retire_i    (retire_i),
   .retire_err_i(retire_err_i),
   .locked_i    (locked_i),
   .count_o     (count_o)
);

// File: tb/insn_exec_counter_tb.sv
module insn_exec_counter_tb_top;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned W          = 8;
   localparam logic [W-1:0] TOP_VAL   = {W{1'b1}};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [1:0]   kind = 2'd0;
   logic         ret = 1'b0;
   logic         err = 1'b0;
   logic         lock = 1'b0;
   logic [W-1:0] cnt;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   logic [W-1:0] m_cnt = '0;
   logic         m_run = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   insn_exec_counter #(.CNT_W(W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .op_start_i(start), .op_kind_i(kind),
      .retire_i(ret), .retire_err_i(err), .locked_i(lock), .count_o(cnt)
   );

   function automatic logic [W-1:0] model_next(input logic [W-1:0] c, input logic run,
                                                input logic s, input logic r, input logic e);
      if (s) return '0;
      if (run && r && !e && c != TOP_VAL) return c + 1'b1;
      return c;
   endfunction

   task automatic check(input string tag);
      logic [W-1:0] exp_v;
      exp_v = lock ? '0 : m_cnt;
      n_cmp++;
      if (cnt !== exp_v) begin
         n_bad++;
         $display("FAIL %s: count_o=%0d expected %0d", tag, cnt, exp_v);
      end
   endtask

   // drive one cycle at negedge, check comb value, then advance model at posedge
   task automatic cyc(input logic s, input logic [1:0] k, input logic r,
                      input logic e, input logic l, input string tag);
      @(negedge clk);
      start = s; kind = k; ret = r; err = e; lock = l;
      #1 check(tag);
      @(posedge clk);
      m_cnt = model_next(m_cnt, m_run, s, r, e);
      if (s) m_run = (k == 2'd0);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      finish_run();
   end

   initial begin
      int unsigned seed;
      string tag;
      logic ps, pr, pe, pl;
      logic [1:0] pk;
      seed = 32'd1234;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R7: reset value and retires before any start are ignored
      cyc(0, 0, 0, 0, 0, "R7");
      for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0, "R7");
      cyc(0, 0, 0, 0, 0, "R7");
      // R6: program run counts good retires
      cyc(1, 2'd0, 0, 0, 0, "R2");
      for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0, 0, "R6");
      // R4: errored retires ignored
      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 0, "R4");
      // R9: hold after operation end
      for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, "R9");
      // R5: lock masks, unlock restores
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, "R5");
      cyc(0, 0, 0, 0, 0, "R5");
      // R1: saturation
      for (int i = 0; i < 270; i++) cyc(0, 0, 1, 0, 0, "R1");
      cyc(0, 0, 0, 0, 0, "R1");
      // R8: start with retire in same cycle
      cyc(1, 2'd0, 1, 0, 0, "R8");
      cyc(0, 0, 0, 0, 0, "R8");
      // R3: wipe and unused kinds do not count
      for (int k = 1; k < 4; k++) begin
         cyc(1, k[1:0], 0, 0, 0, "R3");
         for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0, 0, "R3");
         cyc(0, 0, 0, 0, 0, "R3");
      end
      // random phase
      ps = 0; pr = 0; pe = 0; pl = 0; pk = 0;
      for (int i = 0; i < 4000; i++) begin
         logic s, r, e, l;
         logic [1:0] k;
         s = ($urandom % 12) == 0;
         k = 2'($urandom % 4);
         if (($urandom % 3) == 0) k = 2'd0;
         r = ($urandom % 2) == 0;
         e = ($urandom % 6) == 0;
         l = ($urandom % 10) == 0;
         if (l) tag = "R5";
         else if (ps && pr) tag = "R8";
         else if (ps) tag = "R2";
         else if (!m_run) tag = "R3";
         else if (m_cnt == TOP_VAL) tag = "R1";
         else if (pr && pe) tag = "R4";
         else if (pr) tag = "R6";
         else tag = "R9";
         cyc(s, k, r, e, l, tag);
         ps = s; pr = r; pe = e; pl = l; pk = k;
      end
      cyc(0, 0, 0, 0, 0, "R9");
      finish_run();
   end
endmodule